// File: doc/BRIEF.md
# Chromosome Crossover and Mutation Engine

This block turns two parent chromosomes into two offspring in a genetic search carried out in hardware. When a start pulse arrives, it splits both parents at one fixed bit boundary and swaps their low-order tails. It then walks the offspring one bit position per clock cycle. At each position it may invert a bit, with a probability set by a threshold input. The random samples come from an internal linear feedback shift register, which is seeded on every start.

An elite input protects the first parent. When it is set, offspring A is a plain copy of parent A: no crossover and no mutation are applied to it. Offspring B is built in the normal way. A threshold of 3 gives a per-bit inversion rate of about 3/256, close to 1%.

The controller has three states:
- `XM_IDLE` waits for start.
- `XM_SWEEP` mutates one bit position per cycle, from bit 0 upward.
- `XM_FINISH` raises the valid flag.

It has four transitions:
- *accept*: IDLE to SWEEP, on start.
- *step*: SWEEP to SWEEP, while positions remain.
- *last*: SWEEP to FINISH, after bit CHROM_W-1.
- *publish*: FINISH to IDLE.

Top module: `xover_mutate_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both offspring read 0 and the valid flag is low.
- R2: Crossover at boundary XOVER_LO (default CHROM_W/2, so 5 for 10 bits) works as follows. Offspring A is parent A's bits above the boundary with parent B's bits [XOVER_LO-1:0]. Offspring B is parent B's upper bits with parent A's low bits.
- R3: At sweep step i (i = 0 to CHROM_W-1, bit 0 first), let S be the generator state. Bit i of offspring A is inverted when S[7:0] < threshold. Bit i of offspring B is inverted when S[15:8] < threshold. Both comparisons are unsigned.
- R4: The generator is a 16-bit Galois register that shifts right. When the bit shifted out is 1, the shifted value is XORed with 16'hB400. The register is loaded from the seed input when start is accepted; a zero seed loads 1. Step 0 uses the loaded value, and the register advances once per step.
- R5: A threshold of 0 inverts no bit, so both offspring equal the crossover result.
- R6: With elite high at start, offspring A equals parent A exactly. Offspring B still receives crossover and mutation.
- R7: The valid flag drops in the cycle after start is accepted. It is first high CHROM_W+1 cycles after the accepting edge, and it stays high until the next accepted start.
- R8: A start pulse during SWEEP or FINISH is ignored. The offspring of the running operation are unchanged by it, and so are its valid timing and its inputs, which were captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only in IDLE |
| parent_a_i | input | CHROM_W | First parent chromosome |
| parent_b_i | input | CHROM_W | Second parent chromosome |
| seed_i | input | LFSR_W | Generator seed (zero is replaced by 1) |
| thresh_i | input | SAMPLE_W | Mutation threshold, out of 256 |
| elite_i | input | 1 | Pass parent A through unchanged as offspring A |
| child_a_o | output | CHROM_W | Offspring A |
| child_b_o | output | CHROM_W | Offspring B |
| child_valid_o | output | 1 | Offspring are complete |

## Verification
Some properties are checked on every cycle:
- The generator never holds zero.
- FINISH is reached only after exactly CHROM_W sweep cycles.
- A rise of the valid flag always comes from FINISH.
- The valid flag clears after an accepted start.
- Offspring stay frozen during the sweep when the operation is elite (for A) or the threshold is zero (for both).

Other behaviours can only be shown by the bench's scenarios, which it compares against an independent bit-serial model. These are:
- the exact bit values produced by crossover and mutation;
- the zero-seed substitution;
- the immunity to a start pulse that arrives while an operation is running.

// File: rtl/xm_pkg.sv
package xm_pkg;
    typedef enum logic [1:0] {
        XM_IDLE   = 2'd0,
        XM_SWEEP  = 2'd1,
        XM_FINISH = 2'd2
    } xm_state_e;
endpackage

// File: rtl/xm_lfsr.sv
module xm_lfsr #(
    parameter int               LFSR_W       = 16,
    parameter logic [LFSR_W-1:0] TAP_MASK    = 16'hB400,
    parameter logic [LFSR_W-1:0] DEFAULT_SEED = 16'd11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              advance_i,
    output logic [LFSR_W-1:0] state_o
);
    localparam logic [LFSR_W-1:0] ONE = LFSR_W'(1);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] next_step;
    logic [LFSR_W-1:0] seed_fixed;

    always_comb begin
        next_step  = state_q >> 1;
        if (state_q[0]) next_step = next_step ^ TAP_MASK;
        seed_fixed = (seed_i == '0) ? ONE : seed_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state_q <= (DEFAULT_SEED == '0) ? ONE : DEFAULT_SEED;
        else if (load_i)     state_q <= seed_fixed;
        else if (advance_i)  state_q <= next_step;
    end

    assign state_o = state_q;

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/xm_crossover.sv
module xm_crossover #(
    parameter int CHROM_W  = 10,
    parameter int XOVER_LO = CHROM_W / 2
) (
    input  logic [CHROM_W-1:0] par_a_i,
    input  logic [CHROM_W-1:0] par_b_i,
    output logic [CHROM_W-1:0] mix_a_o,
    output logic [CHROM_W-1:0] mix_b_o
);
    for (genvar g = 0; g < CHROM_W; g++) begin : g_bit
        if (g < XOVER_LO) begin : g_tail
            assign mix_a_o[g] = par_b_i[g];
            assign mix_b_o[g] = par_a_i[g];
        end else begin : g_head
            assign mix_a_o[g] = par_a_i[g];
            assign mix_b_o[g] = par_b_i[g];
        end
    end
endmodule

// File: rtl/xover_mutate_unit.sv
module xover_mutate_unit
    import xm_pkg::*;
#(
    parameter int                CHROM_W      = 10,
    parameter int                XOVER_LO     = CHROM_W / 2,
    parameter int                LFSR_W       = 16,
    parameter int                SAMPLE_W     = 8,
    parameter logic [LFSR_W-1:0] TAP_MASK     = 16'hB400,
    parameter logic [LFSR_W-1:0] DEFAULT_SEED = 16'd11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CHROM_W-1:0]  parent_a_i,
    input  logic [CHROM_W-1:0]  parent_b_i,
    input  logic [LFSR_W-1:0]   seed_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    input  logic                elite_i,
    output logic [CHROM_W-1:0]  child_a_o,
    output logic [CHROM_W-1:0]  child_b_o,
    output logic                child_valid_o
);
    localparam int IDX_W = (CHROM_W > 1) ? $clog2(CHROM_W) : 1;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHROM_W - 1);
    localparam logic [CHROM_W-1:0] BIT0  = CHROM_W'(1);

    xm_state_e state_q, state_d;

    logic [CHROM_W-1:0]  mix_a, mix_b;
    logic [CHROM_W-1:0]  child_a_q, child_b_q;
    logic [IDX_W-1:0]    idx_q;
    logic [SAMPLE_W-1:0] thr_q;
    logic                elite_q;
    logic                valid_q;
    logic [LFSR_W-1:0]   rnd;
    logic                accept, sweeping;
    logic                flip_a, flip_b;
    logic [CHROM_W-1:0]  mask_a, mask_b;

    xm_crossover #(.CHROM_W(CHROM_W), .XOVER_LO(XOVER_LO)) u_xover (
        .par_a_i (parent_a_i),
        .par_b_i (parent_b_i),
        .mix_a_o (mix_a),
        .mix_b_o (mix_b)
    );

    assign accept   = start_i && (state_q == XM_IDLE);
    assign sweeping = (state_q == XM_SWEEP);

    xm_lfsr #(.LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK), .DEFAULT_SEED(DEFAULT_SEED)) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .seed_i    (seed_i),
        .advance_i (sweeping),
        .state_o   (rnd)
    );

    always_comb begin
        flip_a = !elite_q && (rnd[SAMPLE_W-1:0] < thr_q);
        flip_b = (rnd[2*SAMPLE_W-1:SAMPLE_W] < thr_q);
        mask_a = (flip_a ? BIT0 : '0) << idx_q;
        mask_b = (flip_b ? BIT0 : '0) << idx_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XM_IDLE:   if (start_i) state_d = XM_SWEEP;
            XM_SWEEP:  if (idx_q == IDX_LAST) state_d = XM_FINISH;
            XM_FINISH: state_d = XM_IDLE;
            default:   state_d = XM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XM_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            child_a_q <= '0;
            child_b_q <= '0;
            idx_q     <= '0;
            thr_q     <= '0;
            elite_q   <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            unique case (state_q)
                XM_IDLE: begin
                    if (start_i) begin
                        child_a_q <= elite_i ? parent_a_i : mix_a;
                        child_b_q <= mix_b;
                        elite_q   <= elite_i;
                        thr_q     <= thresh_i;
                        idx_q     <= '0;
                        valid_q   <= 1'b0;
                    end
                end
                XM_SWEEP: begin
                    child_a_q <= child_a_q ^ mask_a;
                    child_b_q <= child_b_q ^ mask_b;
                    idx_q     <= idx_q + 1'b1;
                end
                XM_FINISH: valid_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign child_a_o     = child_a_q;
    assign child_b_o     = child_b_q;
    assign child_valid_o = valid_q;

    // checker-side count of cycles spent sweeping
    logic [CNT_W-1:0] sweep_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    sweep_len <= '0;
        else if (state_q == XM_IDLE)   sweep_len <= '0;
        else if (state_q == XM_SWEEP)  sweep_len <= sweep_len + 1'b1;
    end

    // R7
    sweep_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XM_FINISH) |-> (sweep_len == CNT_W'(CHROM_W)));

    // R7
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> ($past(state_q) == XM_FINISH));

    // R7
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == XM_IDLE) |=> !valid_q);

    // R6
    elite_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XM_SWEEP && elite_q) |=> $stable(child_a_q));

    // R5
    zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XM_SWEEP && thr_q == '0) |=> ($stable(child_a_q) && $stable(child_b_q)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XM_SWEEP && start_i) |=> (state_q != XM_IDLE));
endmodule

// File: tb/xover_mutate_unit_tb.sv
module xover_mutate_unit_tb;
    localparam int W  = 10;
    localparam int LO = W / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  pa = '0, pb = '0;
    logic [15:0]   seed = '0;
    logic [7:0]    thr = '0;
    logic          elite = 1'b0;
    logic [W-1:0]  ca, cb;
    logic          cvalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    xover_mutate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .parent_a_i(pa), .parent_b_i(pb), .seed_i(seed),
        .thresh_i(thr), .elite_i(elite),
        .child_a_o(ca), .child_b_o(cb), .child_valid_o(cvalid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lstep(logic [15:0] s);
        logic [15:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    function automatic logic [2*W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                             logic [15:0] sd, logic [7:0] t, logic el);
        logic [W-1:0] xa, xb;
        logic [15:0]  s;
        for (int i = 0; i < W; i++) begin
            xa[i] = (i < LO) ? b[i] : a[i];
            xb[i] = (i < LO) ? a[i] : b[i];
        end
        if (el) xa = a;
        s = (sd == 16'd0) ? 16'd1 : sd;
        for (int i = 0; i < W; i++) begin
            if (!el && s[7:0] < t) xa[i] = ~xa[i];
            if (s[15:8] < t)       xb[i] = ~xb[i];
            s = lstep(s);
        end
        return {xa, xb};
    endfunction

    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [15:0] sd,
                          logic [7:0] t, logic el, bit poke, string tag);
        logic [2*W-1:0] exp;
        exp = model(a, b, sd, t, el);
        @(negedge clk);
        pa = a; pb = b; seed = sd; thr = t; elite = el; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R7 valid cleared after start ", tag}, 32'(cvalid), 32'd0);
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            if (poke && k == 2) begin
                start = 1'b1; pa = ~a; pb = ~b; seed = sd + 16'd7;
                thr = 8'hFF; elite = ~el;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk({"R7 valid low at W cycles ", tag}, 32'(cvalid), 32'd0);
        @(negedge clk);
        chk({"R7 valid high at W+1 cycles ", tag}, 32'(cvalid), 32'd1);
        chk({"R3 offspring A ", tag}, 32'(ca), 32'(exp[2*W-1:W]));
        chk({"R3 offspring B ", tag}, 32'(cb), 32'(exp[W-1:0]));
        @(negedge clk);
        chk({"R7 valid held ", tag}, 32'(cvalid), 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(cvalid), 32'd0);
        chk("R1 child A in reset", 32'(ca), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(cvalid), 32'd0);
        chk("R1 child B after reset", 32'(cb), 32'd0);

        // R2 R5: split example with mutation off
        run_op(10'b1001100100, 10'b0110010110, 16'd11, 8'd0, 1'b0, 1'b0, "R2 example");
        chk("R2 crossover A", 32'(ca), 32'(10'b1001110110));
        chk("R2 crossover B", 32'(cb), 32'(10'b0110000100));
        chk("R5 thr0 A equals crossover", 32'(ca), 32'({pa[W-1:LO], pb[LO-1:0]}));

        // R4: zero seed behaves as seed 1, heavy mutation
        run_op(10'h2A5, 10'h15A, 16'd0, 8'd255, 1'b0, 1'b0, "R4 zero seed");
        run_op(10'h2A5, 10'h15A, 16'd1, 8'd255, 1'b0, 1'b0, "R4 seed one");

        // R6: elite with full mutation
        run_op(10'h3C3, 10'h0F0, 16'hACE1, 8'd200, 1'b1, 1'b0, "R6 elite");
        chk("R6 elite A equals parent A", 32'(ca), 32'(10'h3C3));

        // R8: start poked during sweep
        run_op(10'h155, 10'h2AA, 16'h1234, 8'd128, 1'b0, 1'b1, "R8 busy start");

        // R3: random mix
        for (int n = 0; n < 40; n++) begin
            logic [7:0] t;
            t = (n % 4 == 0) ? 8'd3 : 8'($urandom_range(0, 255));
            run_op(W'($urandom), W'($urandom), 16'($urandom), t,
                   1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), "R3 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule